// File: doc/BRIEF.md
# Display Load Detection Sequencer

This block decides whether an analog monitor hangs on the first video output. It masters a small register port and runs a fixed routine against three registers that belong to the display path: the output-routing register, the converter test-control register and the test-level register. A one-cycle start pulse launches the routine.

The routine first captures the routing and test-control registers. It then powers the converter and quiets the analog outputs. After a settle interval it re-enables the primary head and loads mid-range test levels. It routes those levels onto the colour lines and waits a second settle interval. It then reads the load-sense status bit. Finally it puts all touched registers back.

The result is returned on a present flag together with a one-cycle done pulse. The settle interval is a cycle count supplied on a port. It is meant to be set to about 1 ms of system clock.

Top module: `load_sense_seq`

## Requirements
- R1: After reset, bus_req_o, busy_o, done_o and present_o are all 0.
- R2: A start pulse while idle raises busy_o the next cycle. The first two bus transactions are a read of the routing register (address 0x04) and then a read of the test-control register (address 0x08). Each read value is kept for later restore.
- R3: The third transaction writes the test-control register with the captured value, with bit 16 cleared. This powers the converter.
- R4: The routing register is written with the captured value ANDed with 0x0000FEEE. After the first settle interval it is read again and written back with bit 0 set.
- R5: The test-level register (address 0x0C) is written with 0x94050140. This places 2 in bits 31:30 and 0x140 in each of the fields 29:20, 19:10 and 9:0.
- R6: The test-control register is read and written back with bit 12 set, so the test levels reach the outputs.
- R7: After the acknowledge of the write that quiets the outputs (R4), and after the acknowledge of the write that routes the test levels (R6), no request is made. The next request rises exactly settle_cycles_i + 3 clock edges after that acknowledge edge. settle_cycles_i = 0 is legal.
- R8: The test-control register is read once more. Bit 28 of that read becomes present_o. done_o pulses for one cycle, one cycle after the acknowledge of the final write. present_o holds until the next run updates it.
- R9: Restore writes come in a fixed order. First the test-control register is written with the sensed value, with bit 12 cleared. Then the routing register gets its captured value. Last, the test-control register gets its captured value. A run is exactly 13 transactions.
- R10: Only one transaction is outstanding at a time. While bus_req_o is high and unacknowledged, bus_we_o, bus_addr_o and bus_wdata_o stay stable. Read data is taken in the cycle bus_ack_i is high.
- R11: A start pulse while busy_o is high has no effect. This includes the cycle in which done_o is high. No extra transaction follows and done_o pulses once per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to run a detection |
| settle_cycles_i | input | CNT_W | Settle interval in clock cycles, taken when each wait begins |
| bus_req_o | output | 1 | Register port request, held until acknowledged |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Register address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Acknowledge; ends the request in this cycle |
| bus_rdata_i | input | 32 | Read data, valid with bus_ack_i |
| busy_o | output | 1 | Routine in progress |
| done_o | output | 1 | One-cycle pulse at the end of a routine |
| present_o | output | 1 | Monitor sensed by the most recent routine |

## Verification
Two events can fall in the same cycle: a new start pulse and the done pulse of the run that is ending. The bench drives start_i so that it is sampled exactly in the done cycle. Its model rules such a start out, since the design is still busy. The bench then expects busy_o to fall the next cycle, no further request, and no second done pulse. A separate case raises start in the middle of a run and judges it the same way. Runs back to back with alternating sense results then show that present_o follows each run.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int unsigned REG_W = 32;

  // bit positions decoded by the register file
  localparam int unsigned HEAD_EN_BIT    = 0;
  localparam int unsigned TEST_ROUTE_BIT = 12;
  localparam int unsigned DAC_PWRDN_BIT  = 16;
  localparam int unsigned LOAD_SENSE_BIT = 28;

  localparam logic [REG_W-1:0] HEAD_EN_M    = REG_W'(1) << HEAD_EN_BIT;
  localparam logic [REG_W-1:0] TEST_ROUTE_M = REG_W'(1) << TEST_ROUTE_BIT;
  localparam logic [REG_W-1:0] DAC_PWRDN_M  = REG_W'(1) << DAC_PWRDN_BIT;
  localparam logic [REG_W-1:0] ROUTE_QUIET_M = 32'h0000_FEEE;

  localparam logic [1:0] TEST_MODE  = 2'b10;
  localparam logic [9:0] TEST_LEVEL = 10'h140;  // ~30% of full scale
  localparam logic [REG_W-1:0] TEST_WORD = {TEST_MODE, TEST_LEVEL, TEST_LEVEL, TEST_LEVEL};

  typedef enum logic [4:0] {
    S_IDLE,
    S_RD_ROUTE,
    S_RD_TCTRL,
    S_DAC_ON,
    S_ROUTE_OFF,
    S_WAIT_A,
    S_RD_ROUTE2,
    S_ROUTE_ON,
    S_TDATA,
    S_RD_TCTRL2,
    S_TEST_ON,
    S_WAIT_B,
    S_SENSE,
    S_TEST_OFF,
    S_RST_ROUTE,
    S_RST_TCTRL,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/lss_bus_master.sv
module lss_bus_master #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              req_q, we_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              hit;

  assign hit = req_q && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= hit;
      if (go_i && !req_q) begin
        req_q   <= 1'b1;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end else if (hit) begin
        req_q <= 1'b0;
      end
      if (hit && !we_q) rdata_q <= rdata_i;
    end
  end

  assign req_o   = req_q;
  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;

  // R10: request fields frozen until acknowledged
  p_req_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !ack_i |=> req_q && $stable(addr_q) && $stable(we_q) && $stable(wdata_q));

  // R10: no second issue while one is pending
  p_one_outstanding_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !ack_i |-> !go_i);

  // R10: completion reported right after acknowledge
  p_done_after_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && ack_i |=> done_o && !req_o);
endmodule

// File: rtl/lss_settle_timer.sv
module lss_settle_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cycles_i,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= cycles_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - ONE;
  end

  assign zero_o = (cnt_q == '0);

  // R7: unloaded counter steps down by one per cycle
  p_count_down_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - ONE);

  // R7: load takes the programmed value
  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(cycles_i));
endmodule

// File: rtl/lss_sequencer.sv
module lss_sequencer
  import lss_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] ROUTE_ADDR = ADDR_W'('h04),
  parameter logic [ADDR_W-1:0] TCTRL_ADDR = ADDR_W'('h08),
  parameter logic [ADDR_W-1:0] TDATA_ADDR = ADDR_W'('h0C)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              settle_zero_i,
  output logic              tmr_load_o,
  output logic              go_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [REG_W-1:0]  wdata_o,
  input  logic              op_done_i,
  input  logic [REG_W-1:0]  rd_data_i,
  output logic              in_wait_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              present_o
);
  seq_state_e       state_q, state_d;
  logic             issued_q;
  logic [REG_W-1:0] save_route_q, save_tctrl_q;
  logic             present_q;
  logic             bus_state;

  function automatic seq_state_e step_after(seq_state_e s);
    case (s)
      S_RD_ROUTE:  return S_RD_TCTRL;
      S_RD_TCTRL:  return S_DAC_ON;
      S_DAC_ON:    return S_ROUTE_OFF;
      S_ROUTE_OFF: return S_WAIT_A;
      S_RD_ROUTE2: return S_ROUTE_ON;
      S_ROUTE_ON:  return S_TDATA;
      S_TDATA:     return S_RD_TCTRL2;
      S_RD_TCTRL2: return S_TEST_ON;
      S_TEST_ON:   return S_WAIT_B;
      S_SENSE:     return S_TEST_OFF;
      S_TEST_OFF:  return S_RST_ROUTE;
      S_RST_ROUTE: return S_RST_TCTRL;
      S_RST_TCTRL: return S_DONE;
      default:     return S_IDLE;
    endcase
  endfunction

  assign bus_state = !(state_q inside {S_IDLE, S_WAIT_A, S_WAIT_B, S_DONE});
  assign go_o      = bus_state && !issued_q;

  // bus operation per step
  always_comb begin
    we_o    = 1'b0;
    addr_o  = ROUTE_ADDR;
    wdata_o = '0;
    case (state_q)
      S_RD_TCTRL, S_RD_TCTRL2, S_SENSE: addr_o = TCTRL_ADDR;
      S_DAC_ON: begin
        we_o = 1'b1; addr_o = TCTRL_ADDR; wdata_o = save_tctrl_q & ~DAC_PWRDN_M;
      end
      S_ROUTE_OFF: begin
        we_o = 1'b1; wdata_o = save_route_q & ROUTE_QUIET_M;
      end
      S_ROUTE_ON: begin
        we_o = 1'b1; wdata_o = rd_data_i | HEAD_EN_M;
      end
      S_TDATA: begin
        we_o = 1'b1; addr_o = TDATA_ADDR; wdata_o = TEST_WORD;
      end
      S_TEST_ON: begin
        we_o = 1'b1; addr_o = TCTRL_ADDR; wdata_o = rd_data_i | TEST_ROUTE_M;
      end
      S_TEST_OFF: begin
        we_o = 1'b1; addr_o = TCTRL_ADDR; wdata_o = rd_data_i & ~TEST_ROUTE_M;
      end
      S_RST_ROUTE: begin
        we_o = 1'b1; wdata_o = save_route_q;
      end
      S_RST_TCTRL: begin
        we_o = 1'b1; addr_o = TCTRL_ADDR; wdata_o = save_tctrl_q;
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    case (state_q)
      S_IDLE:   if (start_i) state_d = S_RD_ROUTE;
      S_WAIT_A: if (settle_zero_i) state_d = S_RD_ROUTE2;
      S_WAIT_B: if (settle_zero_i) state_d = S_SENSE;
      S_DONE:   state_d = S_IDLE;
      default: begin
        if (op_done_i) begin
          state_d    = step_after(state_q);
          tmr_load_o = state_q inside {S_ROUTE_OFF, S_TEST_ON};
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      issued_q     <= 1'b0;
      save_route_q <= '0;
      save_tctrl_q <= '0;
      present_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (go_o)           issued_q <= 1'b1;
      else if (op_done_i) issued_q <= 1'b0;
      if (op_done_i) begin
        if (state_q == S_RD_ROUTE) save_route_q <= rd_data_i;
        if (state_q == S_RD_TCTRL) save_tctrl_q <= rd_data_i;
        if (state_q == S_SENSE)    present_q    <= rd_data_i[LOAD_SENSE_BIT];
      end
    end
  end

  assign in_wait_o = (state_q == S_WAIT_A) || (state_q == S_WAIT_B);
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = (state_q == S_DONE);
  assign present_o = present_q;

  // R11: idle without start stays idle
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_IDLE && !start_i |=> state_q == S_IDLE);

  // R11: a busy sequence is never restarted
  p_no_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != S_IDLE |=> state_q != S_RD_ROUTE || $past(state_q) == S_RD_ROUTE);

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);

  // R8: present only moves on the sense step
  p_present_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != S_SENSE |=> $stable(present_q));
endmodule

// File: rtl/load_sense_seq.sv
module load_sense_seq #(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       CNT_W      = 20,
  parameter logic [ADDR_W-1:0] ROUTE_ADDR = ADDR_W'('h04),
  parameter logic [ADDR_W-1:0] TCTRL_ADDR = ADDR_W'('h08),
  parameter logic [ADDR_W-1:0] TDATA_ADDR = ADDR_W'('h0C)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  settle_cycles_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [31:0]       bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              present_o
);
  import lss_pkg::*;

  logic              go, op_we, op_done, tmr_load, tmr_zero, in_wait;
  logic [ADDR_W-1:0] op_addr;
  logic [REG_W-1:0]  op_wdata, rd_data;

  lss_sequencer #(
    .ADDR_W    (ADDR_W),
    .ROUTE_ADDR(ROUTE_ADDR),
    .TCTRL_ADDR(TCTRL_ADDR),
    .TDATA_ADDR(TDATA_ADDR)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .settle_zero_i(tmr_zero),
    .tmr_load_o   (tmr_load),
    .go_o         (go),
    .we_o         (op_we),
    .addr_o       (op_addr),
    .wdata_o      (op_wdata),
    .op_done_i    (op_done),
    .rd_data_i    (rd_data),
    .in_wait_o    (in_wait),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .present_o    (present_o)
  );

  lss_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tmr_load),
    .cycles_i(settle_cycles_i),
    .zero_o  (tmr_zero)
  );

  lss_bus_master #(.ADDR_W(ADDR_W), .DATA_W(REG_W)) u_bus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .we_i   (op_we),
    .addr_i (op_addr),
    .wdata_i(op_wdata),
    .req_o  (bus_req_o),
    .we_o   (bus_we_o),
    .addr_o (bus_addr_o),
    .wdata_o(bus_wdata_o),
    .ack_i  (bus_ack_i),
    .rdata_i(bus_rdata_i),
    .done_o (op_done),
    .rdata_o(rd_data)
  );

  // R7: bus quiet during settle waits
  p_wait_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_wait |-> !bus_req_o);

  // R8: done never overlaps a request
  p_done_no_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o);

  // R1: no request while idle
  p_idle_no_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !bus_req_o);
endmodule

// File: tb/load_sense_seq_bench.sv
module load_sense_seq_bench;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 20;
  localparam logic [7:0] A_ROUTE = 8'h04, A_TCTRL = 8'h08, A_TDATA = 8'h0C;
  localparam logic [31:0] LEVEL_WORD = 32'h9405_0140;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [CNT_W-1:0] settle = '0;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic bus_req, bus_we, busy, done, present;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0] bus_wdata;

  load_sense_seq u_load_sense_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .settle_cycles_i(settle),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .busy_o(busy), .done_o(done), .present_o(present)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] reg_route, reg_tctrl, reg_tdata, r0, t0, last_rd;
  bit mon, model_busy, end_flag, start_at_edge, req_prev, we_prev;
  logic [7:0] addr_prev;
  logic [31:0] wd_prev;
  int lat, lat_cnt, idx, last_ack_edge;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic bit sense_now();
    return mon && reg_route[0] && reg_tctrl[12] && !reg_tctrl[16] && reg_tdata == LEVEL_WORD;
  endfunction

  // expected transaction list from the requirements
  task automatic exp_of(input int k, output bit ew, output logic [7:0] ea,
                        output logic [31:0] ed, output string tag);
    ed = '0;
    case (k)
      0:  begin ew = 0; ea = A_ROUTE; tag = "R2 read route"; end
      1:  begin ew = 0; ea = A_TCTRL; tag = "R2 read tctrl"; end
      2:  begin ew = 1; ea = A_TCTRL; ed = t0 & 32'hFFFE_FFFF; tag = "R3 power dac"; end
      3:  begin ew = 1; ea = A_ROUTE; ed = r0 & 32'h0000_FEEE; tag = "R4 quiet route"; end
      4:  begin ew = 0; ea = A_ROUTE; tag = "R4 reread route"; end
      5:  begin ew = 1; ea = A_ROUTE; ed = last_rd | 32'h1; tag = "R4 head on"; end
      6:  begin ew = 1; ea = A_TDATA; ed = LEVEL_WORD; tag = "R5 test levels"; end
      7:  begin ew = 0; ea = A_TCTRL; tag = "R6 read tctrl"; end
      8:  begin ew = 1; ea = A_TCTRL; ed = last_rd | 32'h1000; tag = "R6 route test"; end
      9:  begin ew = 0; ea = A_TCTRL; tag = "R8 sense read"; end
      10: begin ew = 1; ea = A_TCTRL; ed = last_rd & ~32'h1000; tag = "R9 test off"; end
      11: begin ew = 1; ea = A_ROUTE; ed = r0; tag = "R9 restore route"; end
      default: begin ew = 1; ea = A_TCTRL; ed = t0; tag = "R9 restore tctrl"; end
    endcase
  endtask

  always @(posedge clk) begin
    cyc++;
    start_at_edge = start_i;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog R8: actual no done by cycle %0d expected done", cyc);
      finish_sim();
    end
  end

  // per-cycle model, register-file slave and checks
  always @(negedge clk) begin
    if (rst_ni) begin
      bit old_busy, ew, exp_done;
      logic [7:0] ea;
      logic [31:0] ed;
      string tag;
      old_busy = model_busy;
      if (end_flag) begin model_busy = 0; end_flag = 0; end
      if (start_at_edge && !old_busy) begin model_busy = 1; idx = 0; end
      chk(busy == model_busy, "R11 busy", {31'd0, busy}, {31'd0, model_busy});

      // R7: quiet gap after the two settle-preceding writes
      if (bus_req && !req_prev && (idx == 4 || idx == 9))
        chk(cyc - last_ack_edge == int'(settle) + 3, "R7 settle gap",
            cyc - last_ack_edge, int'(settle) + 3);
      // R10: fields stable while pending
      if (bus_req && req_prev)
        chk(bus_addr == addr_prev && bus_we == we_prev && bus_wdata == wd_prev,
            "R10 stable request", bus_wdata, wd_prev);

      if (bus_ack) begin
        bus_ack = 0;
      end else if (bus_req) begin
        if (lat_cnt >= lat) begin
          lat_cnt = 0;
          if (!model_busy || idx >= 13) begin
            chk(0, "R11 extra transaction", idx, 13);
          end else begin
            exp_of(idx, ew, ea, ed, tag);
            chk(bus_we == ew, tag, {31'd0, bus_we}, {31'd0, ew});
            chk(bus_addr == ea, tag, {24'd0, bus_addr}, {24'd0, ea});
            if (ew) chk(bus_wdata == ed, tag, bus_wdata, ed);
          end
          if (bus_we) begin
            case (bus_addr)
              A_ROUTE: reg_route = bus_wdata;
              A_TCTRL: reg_tctrl = bus_wdata;
              A_TDATA: reg_tdata = bus_wdata;
              default: ;
            endcase
          end else begin
            case (bus_addr)
              A_ROUTE: bus_rdata = reg_route;
              A_TCTRL: bus_rdata = {reg_tctrl[31:29], sense_now(), reg_tctrl[27:0]};
              A_TDATA: bus_rdata = reg_tdata;
              default: bus_rdata = '0;
            endcase
            last_rd = bus_rdata;
          end
          bus_ack = 1;
          last_ack_edge = cyc + 1;
          idx++;
        end else begin
          lat_cnt++;
        end
      end

      exp_done = (idx == 13) && model_busy && (cyc == last_ack_edge + 1);
      if (done || exp_done) chk(done == exp_done, "R8 done pulse", {31'd0, done}, {31'd0, exp_done});
      if (exp_done) end_flag = 1;

      req_prev = bus_req; addr_prev = bus_addr; we_prev = bus_we; wd_prev = bus_wdata;
    end
  end

  task automatic run_case(input logic [31:0] route0, input logic [31:0] tctrl0, input bit m,
                          input int l, input int st, input int poke_at, input bit poke_done);
    int n;
    @(negedge clk);
    r0 = route0; t0 = tctrl0; reg_route = route0; reg_tctrl = tctrl0; reg_tdata = '0;
    mon = m; lat = l; settle = CNT_W'(st); start_i = 1;
    @(negedge clk);
    start_i = 0;
    n = 1;
    while (!done) begin
      @(negedge clk);
      n++;
      start_i = (n == poke_at);
    end
    chk(present == m, "R8 present at done", {31'd0, present}, {31'd0, m});
    if (poke_done) start_i = 1;   // sampled in the done cycle
    @(negedge clk);
    start_i = 0;
    chk(!busy, "R11 start in done cycle ignored", {31'd0, busy}, 32'd0);
    repeat (st + 12) @(negedge clk);
    chk(!bus_req && !busy, "R11 no new run", {31'd0, bus_req}, 32'd0);
    chk(reg_route == route0, "R9 route restored", reg_route, route0);
    chk(reg_tctrl == tctrl0, "R9 tctrl restored", reg_tctrl, tctrl0);
    chk(present == m, "R8 present held", {31'd0, present}, {31'd0, m});
  endtask

  initial begin
    reg_route = '0; reg_tctrl = '0; reg_tdata = '0; r0 = '0; t0 = '0; last_rd = '0;
    mon = 0; model_busy = 0; end_flag = 0; start_at_edge = 0; req_prev = 0; we_prev = 0;
    addr_prev = '0; wd_prev = '0; lat = 0; lat_cnt = 0; idx = 0; last_ack_edge = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(!bus_req && !busy && !done && !present, "R1 reset state",
        {28'd0, bus_req, busy, done, present}, 32'd0);
    run_case(32'h0001_1111, 32'h0001_0040, 1'b1, 0, 5, 0, 1'b0);
    run_case(32'hFFFF_EFFF, 32'h0001_0005, 1'b0, 2, 0, 0, 1'b0);
    run_case(32'h0000_0010, 32'h0000_0A00, 1'b1, 3, 17, 20, 1'b0);
    run_case(32'h1234_5679, 32'h0FFF_0FFF, 1'b1, 1, 3, 0, 1'b1);
    run_case(32'h0000_0001, 32'h0001_0000, 1'b0, 0, 1, 4, 1'b1);
    finish_sim();
  end
endmodule